// File: doc/BRIEF.md
# Open-Row DRAM Bank with Prefetch Burst

This block is a synthesizable behavioural model of a single DRAM bank. It holds a small array of rows, a wide row latch that stands in for the sense amplifiers, and a prefetch buffer placed in front of a narrow data port. A requester presents a row and a column address while the bank is idle. If that row is not the one held in the latch, the bank runs three phases in order: precharge, activate and column select. If the row is already open, the bank runs only the column-select phase.

After column select, the prefetch buffer takes an aligned group of adjacent words from the latched row. It sends them out on consecutive cycles with no further addressing. The group holds 4 words in 4n mode and 8 words in 8n mode. A strobe marks each word, a flag marks the last one, and a status bit reports with the first word whether the access found its row already open. Array contents are a fixed function of row and column, so the model needs no write path.

Top module: `dram_prefetch_bank`

## Requirements
- R1: After reset `ready` is 1, `rd_valid`, `rd_last` and `row_hit` are 0, and no row is open, so the first access is a miss.
- R2: A request accepted while the bank is idle goes through the three phases when its row is not open. The first word then appears in the cycle numbered T_PRE+T_ACT+T_CL+1 after the accepting clock edge. With the defaults that is cycle 9.
- R3: A request whose row is already open skips precharge and activate. Its first word appears in cycle T_CL+1 after the accepting edge, which is cycle 3 with the defaults.
- R4: Each request produces exactly PREFETCH consecutive cycles with `rd_valid` high. `rd_last` is high only on the final one of these cycles.
- R5: The burst starts at the requested column with its low log2(PREFETCH) bits cleared. Words leave in ascending column order.
- R6: The word at row r, column c equals the low DATA_W bits of ((r*40503 + c*257) XOR 0xA5C3).
- R7: `row_hit` is 1 together with the first word of a burst when that access skipped precharge and activate. It is 0 in every other cycle.
- R8: `ready` is 0 from the accepting edge until the burst ends. `req_valid` asserted while `ready` is 0 is ignored: it neither starts an access nor changes which row is open.
- R9: A request to a different row than the open one is a miss and opens the new row. A later request to that new row then hits.
- R10: With PREFETCH = 8, one request delivers 8 words from the aligned 8-word group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe, taken only while `ready` is high |
| req_row | input | ROW_AW (4) | Row address of the request |
| req_col | input | COL_AW (7) | Column (dataword) address of the request |
| ready | output | 1 | Bank idle, able to accept a request |
| rd_valid | output | 1 | Burst word valid |
| rd_data | output | DATA_W (16) | Burst word |
| rd_last | output | 1 | Final word of the burst |
| row_hit | output | 1 | First word of an access that found its row open |

## Verification
The bench times every access from its accepting edge. A controller that ran precharge on a hit, or skipped a phase on a miss, lands the first word in the wrong cycle. Requests aimed at columns in the middle of a group and at column 127 catch a buffer that does not align the group start or that emits words in reverse order. Requests to a different row, and back again, expose a design that leaves the old row marked as open. Requests held high during a busy access catch a controller that accepts work while not idle, or that lets such a request change the open row, since either one changes the hit or miss outcome of the next access.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_CS,
        ST_BURST
    } bank_state_e;

    // Fixed content of the cell array: a pure function of row and column.
    function automatic logic [31:0] cell_word(input int unsigned r, input int unsigned c);
        logic [31:0] mix;
        mix = (32'(r) * 32'd40503) + (32'(c) * 32'd257);
        return mix ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/dram_row_store.sv
module dram_row_store #(
    parameter int ROW_BITS = 2048,
    parameter int DATA_W   = 16,
    parameter int NUM_ROWS = 16,
    localparam int COLS    = ROW_BITS / DATA_W,
    localparam int ROW_AW  = $clog2(NUM_ROWS)
) (
    input  logic [ROW_AW-1:0]   row_idx,
    output logic [ROW_BITS-1:0] row_bits
);

    // One whole row appears at once; each column slice is computed.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign row_bits[c*DATA_W +: DATA_W] =
            DATA_W'(dram_bank_pkg::cell_word(int'(row_idx), c));
    end

endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl #(
    parameter int NUM_ROWS = 16,
    parameter int COLS     = 128,
    parameter int PREFETCH = 4,
    parameter int T_PRE    = 3,
    parameter int T_ACT    = 3,
    parameter int T_CL     = 2,
    localparam int ROW_AW  = $clog2(NUM_ROWS),
    localparam int COL_AW  = $clog2(COLS),
    localparam int PF_AW   = $clog2(PREFETCH),
    localparam int T_MAX   = (T_PRE > T_ACT) ? ((T_PRE > T_CL) ? T_PRE : T_CL)
                                             : ((T_ACT > T_CL) ? T_ACT : T_CL),
    localparam int CNT_W   = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_AW-1:0] req_row,
    input  logic [COL_AW-1:0] req_col,
    output logic              ready,
    output logic [ROW_AW-1:0] row_sel,
    output logic              ld_row,
    output logic              ld_group,
    output logic              shift,
    output logic [COL_AW-1:0] grp_start,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              row_hit
);
    import dram_bank_pkg::*;

    typedef struct packed {
        bank_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_AW-1:0] open_row;
        logic              open_ok;
        logic [ROW_AW-1:0] cur_row;
        logic [COL_AW-1:0] start;
        logic              hit;
        logic [PF_AW-1:0]  beat;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        ld_row   = 1'b0;
        ld_group = 1'b0;
        shift    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.cur_row = req_row;
                    ctl_d.start   = req_col & ~COL_AW'(PREFETCH - 1);
                    if (ctl_q.open_ok && (ctl_q.open_row == req_row)) begin
                        ctl_d.hit = 1'b1;
                        ctl_d.st  = ST_CS;
                        ctl_d.cnt = CNT_W'(T_CL - 1);
                    end else begin
                        ctl_d.hit     = 1'b0;
                        ctl_d.st      = ST_PRE;
                        ctl_d.cnt     = CNT_W'(T_PRE - 1);
                        ctl_d.open_ok = 1'b0;
                    end
                end
            end
            ST_PRE: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_ACT;
                    ctl_d.cnt = CNT_W'(T_ACT - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (ctl_q.cnt == '0) begin
                    ld_row         = 1'b1;
                    ctl_d.open_row = ctl_q.cur_row;
                    ctl_d.open_ok  = 1'b1;
                    ctl_d.st       = ST_CS;
                    ctl_d.cnt      = CNT_W'(T_CL - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_CS: begin
                if (ctl_q.cnt == '0) begin
                    ld_group   = 1'b1;
                    ctl_d.st   = ST_BURST;
                    ctl_d.beat = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_BURST: begin
                shift      = 1'b1;
                ctl_d.beat = ctl_q.beat + 1'b1;
                if (ctl_q.beat == PF_AW'(PREFETCH - 1)) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready     = (ctl_q.st == ST_IDLE);
    assign row_sel   = ctl_q.cur_row;
    assign grp_start = ctl_q.start;
    assign rd_valid  = (ctl_q.st == ST_BURST);
    assign rd_last   = rd_valid && (ctl_q.beat == PF_AW'(PREFETCH - 1));
    assign row_hit   = rd_valid && (ctl_q.beat == '0) && ctl_q.hit;

endmodule

// File: rtl/dram_prefetch_buf.sv
module dram_prefetch_buf #(
    parameter int ROW_BITS = 2048,
    parameter int DATA_W   = 16,
    parameter int PREFETCH = 4,
    localparam int COLS    = ROW_BITS / DATA_W,
    localparam int COL_AW  = $clog2(COLS),
    localparam int GRP_W   = PREFETCH * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_row,
    input  logic [ROW_BITS-1:0] row_bits,
    input  logic                ld_group,
    input  logic [COL_AW-1:0]   grp_start,
    input  logic                shift,
    output logic [DATA_W-1:0]   word
);

    typedef struct packed {
        logic [ROW_BITS-1:0] latch;
        logic [GRP_W-1:0]    grp;
    } pf_t;

    pf_t pf_d, pf_q;

    always_comb begin
        pf_d = pf_q;
        if (ld_row) begin
            pf_d.latch = row_bits;
        end
        if (ld_group) begin
            pf_d.grp = pf_q.latch[int'(grp_start) * DATA_W +: GRP_W];
        end else if (shift) begin
            pf_d.grp = pf_q.grp >> DATA_W;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else begin
            pf_q <= pf_d;
        end
    end

    assign word = pf_q.grp[DATA_W-1:0];

endmodule

// File: rtl/dram_prefetch_bank.sv
module dram_prefetch_bank #(
    parameter int ROW_BITS = 2048,
    parameter int DATA_W   = 16,
    parameter int NUM_ROWS = 16,
    parameter int PREFETCH = 4,
    parameter int T_PRE    = 3,
    parameter int T_ACT    = 3,
    parameter int T_CL     = 2,
    localparam int COLS    = ROW_BITS / DATA_W,
    localparam int ROW_AW  = $clog2(NUM_ROWS),
    localparam int COL_AW  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_AW-1:0] req_row,
    input  logic [COL_AW-1:0] req_col,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              row_hit
);

    logic [ROW_AW-1:0]   row_sel;
    logic [ROW_BITS-1:0] row_bits;
    logic                ld_row;
    logic                ld_group;
    logic                shift;
    logic [COL_AW-1:0]   grp_start;

    dram_row_store #(
        .ROW_BITS(ROW_BITS), .DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS)
    ) u_store (
        .row_idx (row_sel),
        .row_bits(row_bits)
    );

    dram_bank_ctrl #(
        .NUM_ROWS(NUM_ROWS), .COLS(COLS), .PREFETCH(PREFETCH),
        .T_PRE(T_PRE), .T_ACT(T_ACT), .T_CL(T_CL)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_row  (req_row),
        .req_col  (req_col),
        .ready    (ready),
        .row_sel  (row_sel),
        .ld_row   (ld_row),
        .ld_group (ld_group),
        .shift    (shift),
        .grp_start(grp_start),
        .rd_valid (rd_valid),
        .rd_last  (rd_last),
        .row_hit  (row_hit)
    );

    dram_prefetch_buf #(
        .ROW_BITS(ROW_BITS), .DATA_W(DATA_W), .PREFETCH(PREFETCH)
    ) u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_row   (ld_row),
        .row_bits (row_bits),
        .ld_group (ld_group),
        .grp_start(grp_start),
        .shift    (shift),
        .word     (rd_data)
    );

endmodule

// File: rtl/dram_prefetch_bank_chk.sv
module dram_prefetch_bank_chk #(
    parameter int PREFETCH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic ready,
    input logic rd_valid,
    input logic rd_last,
    input logic row_hit
);

    logic [7:0] beats;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (rd_valid) begin
            beats <= rd_last ? 8'd0 : beats + 8'd1;
        end
    end

    p_last_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (rd_valid && (beats == 8'(PREFETCH - 1))));

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (beats < 8'(PREFETCH)));

    p_burst_gapless_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_last) |=> rd_valid);

    p_hit_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_hit |-> (rd_valid && (beats == 8'd0)));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rd_valid);

    p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> (ready && !rd_valid));

endmodule

bind dram_prefetch_bank dram_prefetch_bank_chk #(.PREFETCH(PREFETCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .ready    (ready),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .row_hit  (row_hit)
);

// File: tb/dram_prefetch_bank_bench.sv
module dram_prefetch_bank_bench;

    localparam int TP = 3, TA = 3, TC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // 4n instance
    logic        req_valid = 1'b0;
    logic [3:0]  req_row = '0;
    logic [6:0]  req_col = '0;
    logic        ready, rd_valid, rd_last, row_hit;
    logic [15:0] rd_data;

    // 8n instance
    logic        b_req_valid = 1'b0;
    logic [3:0]  b_req_row = '0;
    logic [6:0]  b_req_col = '0;
    logic        b_ready, b_rd_valid, b_rd_last, b_row_hit;
    logic [15:0] b_rd_data;

    dram_prefetch_bank u_dram_prefetch_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_col(req_col), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .row_hit(row_hit)
    );

    dram_prefetch_bank #(.PREFETCH(8)) u_dram_prefetch_bank_8n (
        .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_row(b_req_row),
        .req_col(b_req_col), .ready(b_ready), .rd_valid(b_rd_valid), .rd_data(b_rd_data),
        .rd_last(b_rd_last), .row_hit(b_row_hit)
    );

    int total = 0;
    int bad = 0;
    int open_row = -1;
    int b_open_row = -1;

    function automatic logic [15:0] exp_word(input int r, input int c);
        logic [31:0] v;
        v = (32'(r) * 32'd40503 + 32'(c) * 32'd257) ^ 32'h0000A5C3;
        return v[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_a(input int r, input int c, input bit poke);
        int n;
        bit exp_hit;
        @(negedge clk);
        while (!ready) @(negedge clk);
        exp_hit = (open_row == r);
        req_valid = 1'b1; req_row = 4'(r); req_col = 7'(c);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        chk(ready == 1'b0, "R8 busy after accept", int'(ready), 0);
        if (poke) begin
            req_valid = 1'b1; req_row = 4'(r ^ 5); req_col = 7'(~c);
        end
        while (!rd_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        if (exp_hit) chk(n == TC + 1, "R3 hit latency", n, TC + 1);
        else         chk(n == TP + TA + TC + 1, "R2 miss latency", n, TP + TA + TC + 1);
        chk(row_hit == exp_hit, "R7 R9 row_hit on first word", int'(row_hit), int'(exp_hit));
        for (int i = 0; i < 4; i++) begin
            chk(rd_valid == 1'b1, "R4 valid in burst", int'(rd_valid), 1);
            chk(rd_data == exp_word(r, (c / 4) * 4 + i), "R5 R6 burst word",
                int'(rd_data), int'(exp_word(r, (c / 4) * 4 + i)));
            chk(rd_last == (i == 3), "R4 last flag", int'(rd_last), int'(i == 3));
            if (i > 0) chk(row_hit == 1'b0, "R7 hit only first", int'(row_hit), 0);
            @(negedge clk);
        end
        chk(rd_valid == 1'b0 && ready == 1'b1, "R8 idle after burst",
            int'({rd_valid, ready}), 1);
        open_row = r;
    endtask

    task automatic read_b(input int r, input int c);
        int n;
        bit exp_hit;
        @(negedge clk);
        while (!b_ready) @(negedge clk);
        exp_hit = (b_open_row == r);
        b_req_valid = 1'b1; b_req_row = 4'(r); b_req_col = 7'(c);
        @(negedge clk);
        b_req_valid = 1'b0;
        n = 1;
        while (!b_rd_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == (exp_hit ? TC + 1 : TP + TA + TC + 1), "R10 8n latency",
            n, exp_hit ? TC + 1 : TP + TA + TC + 1);
        chk(b_row_hit == exp_hit, "R10 8n row_hit", int'(b_row_hit), int'(exp_hit));
        for (int i = 0; i < 8; i++) begin
            chk(b_rd_valid == 1'b1, "R10 8n valid", int'(b_rd_valid), 1);
            chk(b_rd_data == exp_word(r, (c / 8) * 8 + i), "R10 8n word",
                int'(b_rd_data), int'(exp_word(r, (c / 8) * 8 + i)));
            chk(b_rd_last == (i == 7), "R10 8n last", int'(b_rd_last), int'(i == 7));
            @(negedge clk);
        end
        chk(b_rd_valid == 1'b0, "R10 8n burst ends", int'(b_rd_valid), 0);
        b_open_row = r;
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        chk(!rd_valid && !rd_last && !row_hit, "R1 outputs low after reset",
            int'({rd_valid, rd_last, row_hit}), 0);

        // directed corners
        read_a(3, 0, 1'b0);    // R1 first access misses
        read_a(3, 5, 1'b0);    // R3 hit, mid-group column
        read_a(3, 127, 1'b0);  // R5 top group
        read_a(7, 0, 1'b0);    // R9 different row misses
        read_a(7, 66, 1'b0);   // R9 new row now hits
        read_a(3, 9, 1'b1);    // R8 poke while busy
        read_a(3, 10, 1'b0);   // R8 poke must not have changed open row

        // constrained random
        for (int k = 0; k < 60; k++) begin
            read_a(int'($urandom % 4), int'($urandom % 128), 1'($urandom % 3 == 0));
        end

        // 8n mode
        read_b(2, 13);
        read_b(2, 20);
        read_b(9, 127);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule